// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product into a 64-bit accumulator. The accumulator is read as a high half and a low half, each 32 bits wide. There are two operation kinds. The long kind multiplies two full 32-bit operands. The word kind multiplies only the low 16 bits of each operand, each taken as signed, so the product is 32 bits. A mode input chooses between wrapping arithmetic and saturating arithmetic. The two kinds saturate in different ways. The long kind clamps the whole accumulator to a signed 48-bit range. The word kind saturates only the low half and reports an overflow by writing 1 into the high half.

Operands arrive with a valid strobe and are taken only while the unit is idle. A single-cycle done pulse marks the first cycle in which the new accumulator value can be seen. A parameter selects the multiplier. It can be a one-cycle array multiplier or a serial shift-add multiplier that takes one cycle per operand bit. A clear input zeroes the accumulator and cancels any operation in progress. A host can load either half of the accumulator while the unit is idle.

Top module: `sat_mac_unit`

## Requirements
- R1: After reset both accumulator halves read 0, and busy and done are both 0.
- R2: A long operation (op_kind=0) with sat_mode=0 adds the 64-bit signed product of opnd_a and opnd_b into the full 64-bit accumulator {acc_hi,acc_lo}, wrapping modulo 2^64.
- R3: A long operation with sat_mode=1 clamps the sum to the range from -2^47 to 2^47-1. The lower limit is 0xFFFF8000_00000000 and the upper limit is 0x00007FFF_FFFFFFFF.
- R4: In a long operation with sat_mode=1, if the 64-bit signed addition itself overflows, the result is the lower limit when the old accumulator was negative and the upper limit otherwise.
- R5: A word operation (op_kind=1) uses only bits 15:0 of each operand, taken as signed, to form a 32-bit product. With sat_mode=0 that product, sign-extended, is added to the full 64-bit accumulator, and a carry can reach acc_hi.
- R6: A word operation with sat_mode=1 adds the product to acc_lo alone, with 32-bit arithmetic. When there is no signed overflow, acc_hi is unchanged and no carry enters it.
- R7: A word operation with sat_mode=1 that overflows 32 bits sets acc_lo to 0x80000000 when the old acc_lo was negative and to 0x7FFFFFFF otherwise, and writes 1 into acc_hi.
- R8: done is high for exactly one cycle, and the updated accumulator is visible in that same cycle. With the default single-cycle multiplier, done is seen in the second cycle after the accepting clock edge.
- R9: An operation is accepted only when busy is 0. An op_valid presented while busy is 1 is ignored.
- R10: clear zeroes both halves on the next edge. It wins over an operation presented in the same cycle, and it cancels an operation in progress. In either case no done is produced.
- R11: host_wr_hi or host_wr_lo loads host_wdata into that half while the unit is idle. A host write made while busy is 1, or in the same cycle as clear, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operand strobe |
| op_kind | input | 1 | 0 selects the long operation, 1 selects the word operation |
| sat_mode | input | 1 | 1 selects saturating arithmetic |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| clear | input | 1 | Zeroes the accumulator and cancels any operation in progress |
| host_wr_hi | input | 1 | Loads host_wdata into the high half |
| host_wr_lo | input | 1 | Loads host_wdata into the low half |
| host_wdata | input | 32 | Data for host writes |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when the accumulator has been updated |
| acc_hi | output | 32 | High half of the accumulator |
| acc_lo | output | 32 | Low half of the accumulator |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is clear and an operation, either being accepted or completing. The second pair is a host write and the commit of a result. The bench raises clear together with op_valid, and raises clear again one cycle after an accepted operation. In both cases it expects a zero accumulator and no done pulse for several cycles afterwards. It also issues a host write to acc_lo in the busy cycle just before the commit, and expects the operation's result to be left intact.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
   typedef enum logic {
      MAC_LONG = 1'b0,
      MAC_WORD = 1'b1
   } mac_kind_e;
endpackage

// File: rtl/sat_mac_mult.sv
module sat_mac_mult #(
   parameter int OPW    = 32,
   parameter bit SERIAL = 1'b0,
   localparam int PW    = 2 * OPW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           flush,
   input  logic           start,
   input  logic [OPW-1:0] a,
   input  logic [OPW-1:0] b,
   output logic [PW-1:0]  prod,
   output logic           prod_vld
);
   generate
      if (!SERIAL) begin : g_array
         logic signed [PW-1:0] ax, bx;
         assign ax = {{OPW{a[OPW-1]}}, a};
         assign bx = {{OPW{b[OPW-1]}}, b};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prod     <= '0;
               prod_vld <= 1'b0;
            end else begin
               prod_vld <= start && !flush;
               if (start) prod <= ax * bx;
            end
         end
      end else begin : g_serial
         localparam int CW = $clog2(OPW + 1);
         logic [PW-1:0]  mcand, accu, accu_nx;
         logic [OPW-1:0] mplier, a_mag, b_mag;
         logic [CW-1:0]  cnt;
         logic           neg, run;
         assign a_mag   = a[OPW-1] ? (~a + 1'b1) : a;
         assign b_mag   = b[OPW-1] ? (~b + 1'b1) : b;
         assign accu_nx = mplier[0] ? (accu + mcand) : accu;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mcand <= '0; accu <= '0; mplier <= '0; cnt <= '0;
               neg <= 1'b0; run <= 1'b0; prod <= '0; prod_vld <= 1'b0;
            end else if (flush) begin
               run      <= 1'b0;
               prod_vld <= 1'b0;
            end else begin
               prod_vld <= 1'b0;
               if (start) begin
                  mcand  <= {{OPW{1'b0}}, a_mag};
                  mplier <= b_mag;
                  accu   <= '0;
                  cnt    <= CW'(OPW);
                  neg    <= a[OPW-1] ^ b[OPW-1];
                  run    <= 1'b1;
               end else if (run) begin
                  accu   <= accu_nx;
                  mcand  <= mcand << 1;
                  mplier <= mplier >> 1;
                  cnt    <= cnt - 1'b1;
                  if (cnt == CW'(1)) begin
                     run      <= 1'b0;
                     prod_vld <= 1'b1;
                     prod     <= neg ? (~accu_nx + 1'b1) : accu_nx;
                  end
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sat_mac_alu.sv
module sat_mac_alu
   import sat_mac_pkg::*;
#(
   parameter int OPW  = 32,
   parameter int SATW = 48,
   localparam int PW  = 2 * OPW
) (
   input  mac_kind_e     kind,
   input  logic          sat,
   input  logic [PW-1:0] acc,
   input  logic [PW-1:0] prod,
   output logic [PW-1:0] nxt
);
   localparam logic [PW-1:0]  MAX_W  = {{(PW-SATW+1){1'b0}}, {(SATW-1){1'b1}}};
   localparam logic [PW-1:0]  MIN_W  = ~MAX_W;
   localparam logic [OPW-1:0] MAX_H  = {1'b0, {(OPW-1){1'b1}}};
   localparam logic [OPW-1:0] MIN_H  = ~MAX_H;
   localparam logic [OPW-1:0] ONE_H  = {{(OPW-1){1'b0}}, 1'b1};

   logic [PW-1:0]    sum_l, pext, sum_w;
   logic [OPW-1:0]   lo, p32, sum_h;
   logic [PW-SATW:0] top_bits;
   logic             ovf_l, in_rng, ovf_h;

   always_comb begin
      sum_l    = acc + prod;
      ovf_l    = (acc[PW-1] == prod[PW-1]) && (sum_l[PW-1] != acc[PW-1]);
      top_bits = sum_l[PW-1:SATW-1];
      in_rng   = (top_bits == '0) || (top_bits == '1);
      p32      = prod[OPW-1:0];
      pext     = {{OPW{p32[OPW-1]}}, p32};
      sum_w    = acc + pext;
      lo       = acc[OPW-1:0];
      sum_h    = lo + p32;
      ovf_h    = (lo[OPW-1] == p32[OPW-1]) && (sum_h[OPW-1] != lo[OPW-1]);
      nxt      = sum_l;
      if (kind == MAC_LONG) begin
         if (sat) begin
            if (ovf_l)        nxt = acc[PW-1] ? MIN_W : MAX_W;
            else if (!in_rng) nxt = sum_l[PW-1] ? MIN_W : MAX_W;
            else              nxt = sum_l;
         end
      end else begin
         if (!sat)       nxt = sum_w;
         else if (ovf_h) nxt = {ONE_H, lo[OPW-1] ? MIN_H : MAX_H};
         else            nxt = {acc[PW-1:OPW], sum_h};
      end
   end
endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit
   import sat_mac_pkg::*;
#(
   parameter int OPW        = 32,
   parameter int HALFW      = 16,
   parameter int SATW       = 48,
   parameter bit SERIAL_MUL = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           op_valid,
   input  logic           op_kind,
   input  logic           sat_mode,
   input  logic [OPW-1:0] opnd_a,
   input  logic [OPW-1:0] opnd_b,
   input  logic           clear,
   input  logic           host_wr_hi,
   input  logic           host_wr_lo,
   input  logic [OPW-1:0] host_wdata,
   output logic           busy,
   output logic           done,
   output logic [OPW-1:0] acc_hi,
   output logic [OPW-1:0] acc_lo
);
   localparam int PW = 2 * OPW;

   generate
      if (SATW <= OPW || SATW >= PW) begin : g_bad_satw
         $error("SATW must lie strictly between OPW and 2*OPW");
      end
      if (2 * HALFW > OPW) begin : g_bad_halfw
         $error("word product must fit in OPW bits");
      end
   endgenerate

   mac_kind_e     kind_q;
   logic          sat_q, accept, host_ok, prod_vld;
   logic [OPW-1:0] a_sel, b_sel;
   logic [PW-1:0] prod, nxt;

   assign accept  = op_valid && !busy && !clear;
   assign host_ok = !busy && !clear;

   assign a_sel = (mac_kind_e'(op_kind) == MAC_WORD)
                ? {{(OPW-HALFW){opnd_a[HALFW-1]}}, opnd_a[HALFW-1:0]} : opnd_a;
   assign b_sel = (mac_kind_e'(op_kind) == MAC_WORD)
                ? {{(OPW-HALFW){opnd_b[HALFW-1]}}, opnd_b[HALFW-1:0]} : opnd_b;

   sat_mac_mult #(.OPW(OPW), .SERIAL(SERIAL_MUL)) mult_i (
      .clk(clk), .rst_n(rst_n), .flush(clear), .start(accept),
      .a(a_sel), .b(b_sel), .prod(prod), .prod_vld(prod_vld)
   );

   sat_mac_alu #(.OPW(OPW), .SATW(SATW)) alu_i (
      .kind(kind_q), .sat(sat_q), .acc({acc_hi, acc_lo}),
      .prod(prod), .nxt(nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_hi <= '0;
         acc_lo <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
         kind_q <= MAC_LONG;
         sat_q  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (clear) begin
            acc_hi <= '0;
            acc_lo <= '0;
            busy   <= 1'b0;
         end else begin
            if (accept) begin
               busy   <= 1'b1;
               kind_q <= mac_kind_e'(op_kind);
               sat_q  <= sat_mode;
            end
            if (prod_vld) begin
               {acc_hi, acc_lo} <= nxt;
               busy <= 1'b0;
               done <= 1'b1;
            end
            if (host_ok && host_wr_hi) acc_hi <= host_wdata;
            if (host_ok && host_wr_lo) acc_lo <= host_wdata;
         end
      end
   end
endmodule

// File: rtl/sat_mac_chk.sv
module sat_mac_chk #(
   parameter int OPW  = 32,
   parameter int SATW = 48
) (
   input logic           clk,
   input logic           rst_n,
   input logic           op_valid,
   input logic           op_kind,
   input logic           sat_mode,
   input logic           clear,
   input logic           busy,
   input logic           done,
   input logic [OPW-1:0] acc_hi,
   input logic [OPW-1:0] acc_lo
);
   logic               rec_word, rec_sat;
   logic [2*OPW-1:0]   acc;
   logic [2*OPW-SATW:0] top_bits;
   assign acc      = {acc_hi, acc_lo};
   assign top_bits = acc[2*OPW-1:SATW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_word <= 1'b0;
         rec_sat  <= 1'b0;
      end else if (op_valid && !busy && !clear) begin
         rec_word <= op_kind;
         rec_sat  <= sat_mode;
      end
   end

   p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (acc_hi == '0 && acc_lo == '0));
   p_clear_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !done);
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !busy && !clear) |=> busy || done);
   p_long_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rec_sat && !rec_word) |-> (top_bits == '0 || top_bits == '1));
   p_word_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rec_sat && rec_word) |->
         (acc_hi == $past(acc_hi) || acc_hi == {{(OPW-1){1'b0}}, 1'b1}));
endmodule

bind sat_mac_unit sat_mac_chk #(.OPW(OPW), .SATW(SATW)) chk_i (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
   .sat_mode(sat_mode), .clear(clear), .busy(busy), .done(done),
   .acc_hi(acc_hi), .acc_lo(acc_lo)
);

// File: tb/sat_mac_unit_tb.sv
module sat_mac_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0, op_kind = 1'b0, sat_mode = 1'b0, clear = 1'b0;
   logic        host_wr_hi = 1'b0, host_wr_lo = 1'b0;
   logic [31:0] opnd_a = '0, opnd_b = '0, host_wdata = '0;
   logic        busy, done;
   logic [31:0] acc_hi, acc_lo;
   int          nchk = 0, nerr = 0;

   always #2 clk = ~clk;

   sat_mac_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .sat_mode(sat_mode), .opnd_a(opnd_a), .opnd_b(opnd_b), .clear(clear),
      .host_wr_hi(host_wr_hi), .host_wr_lo(host_wr_lo), .host_wdata(host_wdata),
      .busy(busy), .done(done), .acc_hi(acc_hi), .acc_lo(acc_lo)
   );

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic set_acc(input logic [31:0] hi, input logic [31:0] lo);
      @(negedge clk); host_wr_hi = 1'b1; host_wdata = hi;
      @(negedge clk); host_wr_hi = 1'b0; host_wr_lo = 1'b1; host_wdata = lo;
      @(negedge clk); host_wr_lo = 1'b0;
   endtask

   task automatic run_op(input logic kind, input logic sat, input logic [31:0] a,
                         input logic [31:0] b, output int lat);
      @(negedge clk); op_valid = 1'b1; op_kind = kind; sat_mode = sat;
      opnd_a = a; opnd_b = b;
      @(negedge clk); op_valid = 1'b0; lat = 1;
      while (!done && lat < 200) begin @(negedge clk); lat++; end
   endtask

   task automatic op_case(input string req, input logic [63:0] init, input logic kind,
                          input logic sat, input logic [31:0] a, input logic [31:0] b,
                          input logic [63:0] exp);
      int lat;
      set_acc(init[63:32], init[31:0]);
      run_op(kind, sat, a, b, lat);
      chk(req, {acc_hi, acc_lo}, exp);
   endtask

   task automatic t_reset;
      chk("R1 acc", {acc_hi, acc_lo}, 64'h0);
      chk("R1 flags", {62'h0, busy, done}, 64'h0);
   endtask

   task automatic t_latency;
      int lat;
      set_acc(32'h0, 32'h0);
      run_op(1'b0, 1'b0, 32'd7, 32'd6, lat);
      chk("R8 latency", 64'(lat), 64'd2);
      chk("R8 value at done", {acc_hi, acc_lo}, 64'd42);
      @(negedge clk);
      chk("R8 single pulse", {63'h0, done}, 64'h0);
   endtask

   task automatic t_busy_ignore;
      int ndone = 0;
      set_acc(32'h0, 32'h0);
      @(negedge clk); op_valid = 1'b1; op_kind = 1'b0; sat_mode = 1'b0;
      opnd_a = 32'd2; opnd_b = 32'd3;
      @(negedge clk);
      @(negedge clk); op_valid = 1'b0;
      ndone += done;
      for (int i = 0; i < 6; i++) begin @(negedge clk); ndone += done; end
      chk("R9 acc one product", {acc_hi, acc_lo}, 64'd6);
      chk("R9 done count", 64'(ndone), 64'd1);
   endtask

   task automatic t_clear;
      int ndone = 0;
      set_acc(32'h1111_2222, 32'h3333_4444);
      @(negedge clk); op_valid = 1'b1; clear = 1'b1; opnd_a = 32'd5; opnd_b = 32'd5;
      op_kind = 1'b0; sat_mode = 1'b0;
      @(negedge clk); op_valid = 1'b0; clear = 1'b0;
      chk("R10 clear wins", {acc_hi, acc_lo}, 64'h0);
      for (int i = 0; i < 5; i++) begin @(negedge clk); ndone += done; end
      chk("R10 no done", 64'(ndone), 64'd0);
      set_acc(32'h0, 32'h9);
      @(negedge clk); op_valid = 1'b1; opnd_a = 32'd4; opnd_b = 32'd4;
      @(negedge clk); op_valid = 1'b0; clear = 1'b1;
      @(negedge clk); clear = 1'b0;
      ndone = 0;
      for (int i = 0; i < 5; i++) begin @(negedge clk); ndone += done; end
      chk("R10 abort acc", {acc_hi, acc_lo}, 64'h0);
      chk("R10 abort no done", 64'(ndone), 64'd0);
   endtask

   task automatic t_host;
      set_acc(32'hCAFE_0001, 32'h0BAD_F00D);
      chk("R11 load", {acc_hi, acc_lo}, 64'hCAFE_0001_0BAD_F00D);
      @(negedge clk); op_valid = 1'b1; op_kind = 1'b0; sat_mode = 1'b0;
      opnd_a = 32'd1; opnd_b = 32'd2;
      @(negedge clk); op_valid = 1'b0; host_wr_lo = 1'b1; host_wdata = 32'h1234_5678;
      @(negedge clk); host_wr_lo = 1'b0;
      chk("R11 ignored while busy", {acc_hi, acc_lo}, 64'hCAFE_0001_0BAD_F00F);
      @(negedge clk); clear = 1'b1; host_wr_hi = 1'b1; host_wdata = 32'hFFFF_FFFF;
      @(negedge clk); clear = 1'b0; host_wr_hi = 1'b0;
      chk("R11 ignored with clear", {acc_hi, acc_lo}, 64'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++; nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      op_case("R2 small", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 32'd3, 32'd5, 64'd14);
      op_case("R2 wrap", 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 32'd1, 32'd1,
              64'h8000_0000_0000_0000);
      op_case("R3 clamp high", 64'h0000_7FFF_FFFF_FFF0, 1'b0, 1'b1, 32'h100, 32'd1,
              64'h0000_7FFF_FFFF_FFFF);
      op_case("R3 clamp low", 64'hFFFF_8000_0000_0010, 1'b0, 1'b1, 32'hFFFF_FFE0, 32'd1,
              64'hFFFF_8000_0000_0000);
      op_case("R3 in range", 64'h0000_0000_0000_0100, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'd16,
              64'h0000_0000_0000_00F0);
      op_case("R4 ovf pos", 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 32'h7FFF_FFFF,
              32'h7FFF_FFFF, 64'h0000_7FFF_FFFF_FFFF);
      op_case("R4 ovf neg", 64'h8000_0000_0000_0000, 1'b0, 1'b1, 32'h8000_0000,
              32'h7FFF_FFFF, 64'hFFFF_8000_0000_0000);
      op_case("R5 low16 only", 64'h0000_0000_FFFF_FFF0, 1'b1, 1'b0, 32'hABCD_0003,
              32'h1234_FFFE, 64'h0000_0000_FFFF_FFEA);
      op_case("R5 carry to hi", 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b0, 32'd1, 32'd1,
              64'h0000_0001_0000_0000);
      op_case("R6 hi kept", 64'h55AA_55AA_0000_0010, 1'b1, 1'b1, 32'h0000_0004,
              32'h0000_FFFD, 64'h55AA_55AA_0000_0004);
      op_case("R6 no carry", 64'h55AA_55AA_FFFF_FFFF, 1'b1, 1'b1, 32'd1, 32'd1,
              64'h55AA_55AA_0000_0000);
      op_case("R7 ovf pos", 64'hDEAD_0000_7FFF_FFF0, 1'b1, 1'b1, 32'h0000_7FFF,
              32'h0000_7FFF, 64'h0000_0001_7FFF_FFFF);
      op_case("R7 ovf neg", 64'hDEAD_0000_8000_0005, 1'b1, 1'b1, 32'h0000_8000,
              32'h0000_7FFF, 64'h0000_0001_8000_0000);
      t_latency();
      t_busy_ignore();
      t_clear();
      t_host();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule